// File: doc/BRIEF.md
# Four-Thread Issue Picker

This block chooses, each clock, which of several hardware threads hands its next instruction pair to decode. Every thread keeps a small ready-to-run buffer of instruction pairs. A thread may issue only when three things hold: it has work, it is not parked on a miss, and its buffer is not empty. The picker also refuses any thread that issued in the previous cycle, so a core with one runnable thread alternates issue cycles with idle cycles. Among the threads that may issue, the search starts at the thread after the last one that issued and goes round in index order.

The same block keeps the buffers filled. It launches at most one refill request to the instruction cache at a time. When the thread that is issuing in the current cycle needs a refill, that thread wins the request. Otherwise the lowest-numbered thread that needs one wins. A miss on a thread, or a redirect to a target that is not in that thread's buffer, flushes that thread alone. A refill that was already under way for a flushed thread is thrown away when it returns.

Top module: `thread_issue_picker`

## Requirements
- R1: After reset, no pair issues, no refill is requested, and every buffer is empty. A thread therefore cannot issue until a refill for it has returned.
- R2: The same thread is never issued in two consecutive cycles.
- R3: The issued thread is the first eligible one found by searching upward from index (last issued + 1) mod NTHR. The search wraps around. Before the first issue it starts at index 0.
- R4: A thread is eligible when its active input is 1, it is not stalled, its buffer holds at least one pair, and it did not issue in the previous cycle. Only an eligible thread issues.
- R5: When the only thread that would otherwise be eligible issued in the previous cycle, `iss_valid_o` is 0 for that cycle.
- R6: A thread needs a refill when all of the following hold: it is active, it is not stalled, it is not being flushed in this cycle, and its buffer will hold fewer than DEPTH pairs after this cycle's issue. If the issuing thread needs a refill it receives the request. Otherwise the lowest-numbered thread that needs one receives it.
- R7: At most one refill is outstanding. `req_valid_o` is a one-cycle pulse that names the thread in `req_tid_o`. A pulse of `fill_done_i` while the refill is outstanding ends it and fills that thread's buffer to DEPTH pairs. A `fill_done_i` pulse with no refill outstanding is ignored.
- R8: If `redir_valid_i` is 1 and `redir_hit_i` is 0, bit `redir_tid_i` of `flush_o` is 1 in that same cycle and that thread's buffer is emptied. A refill outstanding for that thread is discarded when it returns. If `redir_hit_i` is 1, the redirect flushes nothing.
- R9: Bit t of `thr_miss_i` raises bit t of `flush_o` in the same cycle, empties buffer t and stalls thread t. The thread stays stalled until a pulse on bit t of `thr_wake_i`. If miss and wake arrive together, the miss wins. Other threads are not affected.
- R10: Each issue takes one pair from the thread's buffer. A full buffer allows exactly DEPTH issues before a further refill is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_active_i | input | NTHR | Per-thread flag: the thread has work |
| thr_miss_i | input | NTHR | Per-thread data miss pulse: flushes and stalls the thread |
| thr_wake_i | input | NTHR | Per-thread pulse: the miss data has returned |
| redir_valid_i | input | 1 | A control transfer is reported |
| redir_tid_i | input | TW | Thread that made the control transfer |
| redir_hit_i | input | 1 | 1 when the target is already held in the buffer |
| fill_done_i | input | 1 | The outstanding refill has completed |
| iss_valid_o | output | 1 | A pair issues in this cycle |
| iss_tid_o | output | TW | Thread that issues |
| req_valid_o | output | 1 | Pulse that launches a refill |
| req_tid_o | output | TW | Thread the refill is for |
| flush_o | output | NTHR | Per-thread buffer flush |

## Verification
The bench builds the block with its defaults: four threads and a buffer depth of two pairs. With these values every active-thread mask can be swept, and the whole issue rotation can be predicted each cycle. The bench plays the instruction cache, returning refills after alternating 4- and 5-cycle latencies. It can also hold a refill back, so that a buffer drains to empty. Randomised misses, wakes and redirects then reach the harder cases: a flush that lands on the thread whose refill is outstanding, a miss and a wake arriving together, and one ready thread alternating with bubbles.

// File: rtl/tip_pkg.sv
`timescale 1ns/1ps
package tip_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_WAIT = 1'b1
  } fill_state_e;
endpackage

// File: rtl/tip_rr_pick.sv
`timescale 1ns/1ps
// First set bit of elig_i found searching upward from start_i, wrapping.
module tip_rr_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] elig_i,
  input  logic [W-1:0] start_i,
  output logic         gnt_v_o,
  output logic [W-1:0] gnt_id_o
);
  always_comb begin
    int idx;
    gnt_v_o  = 1'b0;
    gnt_id_o = '0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(start_i) + k) % N;
      if (!gnt_v_o && elig_i[idx]) begin
        gnt_v_o  = 1'b1;
        gnt_id_o = W'(idx);
      end
    end
  end
endmodule

// File: rtl/tip_thr_slot.sv
`timescale 1ns/1ps
// Per-thread buffer occupancy and miss stall state.
module tip_thr_slot #(
  parameter int DEPTH = 2,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          fill_i,
  input  logic          flush_i,
  input  logic          miss_i,
  input  logic          wake_i,
  output logic [CW-1:0] cnt_o,
  output logic          stalled_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          stall_q, stall_d, stall_en;

  always_comb begin
    cnt_d = cnt_q;
    if (issue_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    if (fill_i)                 cnt_d = CW'(DEPTH);
    if (flush_i)                cnt_d = '0;
    cnt_en   = issue_i | fill_i | flush_i;
    stall_en = miss_i | wake_i;
    stall_d  = miss_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stall_q <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (stall_en) stall_q <= stall_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign stalled_o = stall_q;
endmodule

// File: rtl/tip_refill.sv
`timescale 1ns/1ps
// Single-outstanding refill launcher with issuing-thread priority.
module tip_refill
  import tip_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] needy_i,
  input  logic         iss_v_i,
  input  logic [W-1:0] iss_id_i,
  input  logic         fill_done_i,
  input  logic [N-1:0] flush_i,
  output logic         req_v_o,
  output logic [W-1:0] req_id_o,
  output logic [N-1:0] fill_o
);
  fill_state_e st_q, st_d;
  logic [W-1:0] tid_q;
  logic         stale_q, stale_d;
  logic         lo_v, launch, ret;
  logic [W-1:0] lo_id;

  tip_rr_pick #(.N(N), .W(W)) u_lowest (
    .elig_i  (needy_i),
    .start_i ('0),
    .gnt_v_o (lo_v),
    .gnt_id_o(lo_id)
  );

  always_comb begin
    launch   = (st_q == FILL_IDLE) && lo_v;
    req_id_o = (iss_v_i && needy_i[iss_id_i]) ? iss_id_i : lo_id;
    ret      = (st_q == FILL_WAIT) && fill_done_i;
    fill_o   = '0;
    if (ret && !stale_q && !flush_i[tid_q]) fill_o[tid_q] = 1'b1;
    st_d = st_q;
    if (launch)   st_d = FILL_WAIT;
    else if (ret) st_d = FILL_IDLE;
    stale_d = stale_q;
    if (launch) stale_d = 1'b0;
    else if (st_q == FILL_WAIT && flush_i[tid_q]) stale_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FILL_IDLE;
      tid_q   <= '0;
      stale_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stale_q <= stale_d;
      if (launch) tid_q <= req_id_o;
    end
  end

  assign req_v_o = launch;
endmodule

// File: rtl/thread_issue_picker.sv
`timescale 1ns/1ps
module thread_issue_picker #(
  parameter int NTHR  = 4,
  parameter int DEPTH = 2,
  localparam int TW   = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] thr_active_i,
  input  logic [NTHR-1:0] thr_miss_i,
  input  logic [NTHR-1:0] thr_wake_i,
  input  logic            redir_valid_i,
  input  logic [TW-1:0]   redir_tid_i,
  input  logic            redir_hit_i,
  input  logic            fill_done_i,
  output logic            iss_valid_o,
  output logic [TW-1:0]   iss_tid_o,
  output logic            req_valid_o,
  output logic [TW-1:0]   req_tid_o,
  output logic [NTHR-1:0] flush_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  logic [CW-1:0]   cnt [NTHR];
  logic [NTHR-1:0] stalled, elig, needy, iss_oh, fill_vec;
  logic            last_v_q;
  logic [TW-1:0]   last_id_q, ptr_q, ptr_d;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [CW-1:0] cnt_after;
    assign flush_o[t] = thr_miss_i[t] |
                        (redir_valid_i && !redir_hit_i && redir_tid_i == TW'(t));
    assign elig[t]    = thr_active_i[t] && !stalled[t] && cnt[t] != '0 &&
                        !(last_v_q && last_id_q == TW'(t));
    assign iss_oh[t]  = iss_valid_o && iss_tid_o == TW'(t);
    assign cnt_after  = cnt[t] - CW'(iss_oh[t]);
    assign needy[t]   = thr_active_i[t] && !stalled[t] && !flush_o[t] &&
                        cnt_after < CW'(DEPTH);

    tip_thr_slot #(.DEPTH(DEPTH), .CW(CW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_l),
      .issue_i  (iss_oh[t]),
      .fill_i   (fill_vec[t]),
      .flush_i  (flush_o[t]),
      .miss_i   (thr_miss_i[t]),
      .wake_i   (thr_wake_i[t]),
      .cnt_o    (cnt[t]),
      .stalled_o(stalled[t])
    );
  end

  tip_rr_pick #(.N(NTHR), .W(TW)) u_pick (
    .elig_i  (elig),
    .start_i (ptr_q),
    .gnt_v_o (iss_valid_o),
    .gnt_id_o(iss_tid_o)
  );

  tip_refill #(.N(NTHR), .W(TW)) u_refill (
    .clk        (clk),
    .rst_n      (rst_l),
    .needy_i    (needy),
    .iss_v_i    (iss_valid_o),
    .iss_id_i   (iss_tid_o),
    .fill_done_i(fill_done_i),
    .flush_i    (flush_o),
    .req_v_o    (req_valid_o),
    .req_id_o   (req_tid_o),
    .fill_o     (fill_vec)
  );

  always_comb begin
    ptr_d = (int'(iss_tid_o) == NTHR - 1) ? '0 : iss_tid_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      last_v_q  <= 1'b0;
      last_id_q <= '0;
      ptr_q     <= '0;
    end else begin
      last_v_q <= iss_valid_o;
      if (iss_valid_o) begin
        last_id_q <= iss_tid_o;
        ptr_q     <= ptr_d;
      end
    end
  end
endmodule

// File: rtl/tip_chk.sv
`timescale 1ns/1ps
module tip_chk #(
  parameter int NTHR = 4,
  parameter int TW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NTHR-1:0] thr_active_i,
  input logic [NTHR-1:0] thr_miss_i,
  input logic            redir_valid_i,
  input logic [TW-1:0]   redir_tid_i,
  input logic            redir_hit_i,
  input logic            iss_valid_o,
  input logic [TW-1:0]   iss_tid_o,
  input logic            req_valid_o,
  input logic [NTHR-1:0] flush_o
);
  p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid_o && $past(iss_valid_o) |-> iss_tid_o != $past(iss_tid_o));

  p_issue_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid_o |-> thr_active_i[iss_tid_o]);

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |=> !req_valid_o);

  p_redir_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_i && !redir_hit_i |-> flush_o[redir_tid_i]);

  p_hit_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_i && redir_hit_i && !thr_miss_i[redir_tid_i] |-> !flush_o[redir_tid_i]);

  p_miss_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o & thr_miss_i) == thr_miss_i);
endmodule

bind thread_issue_picker tip_chk #(.NTHR(NTHR), .TW(TW)) u_tip_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .thr_active_i (thr_active_i),
  .thr_miss_i   (thr_miss_i),
  .redir_valid_i(redir_valid_i),
  .redir_tid_i  (redir_tid_i),
  .redir_hit_i  (redir_hit_i),
  .iss_valid_o  (iss_valid_o),
  .iss_tid_o    (iss_tid_o),
  .req_valid_o  (req_valid_o),
  .flush_o      (flush_o)
);

// File: tb/test_thread_issue_picker.sv
`timescale 1ns/1ps
module test_thread_issue_picker;
  localparam int N = 4;
  localparam int D = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [N-1:0] act, miss, wake;
  logic rv, rhit, fd;
  logic [1:0] rtid;
  logic iss_valid_o, req_valid_o;
  logic [1:0] iss_tid_o, req_tid_o;
  logic [N-1:0] flush_o;

  thread_issue_picker #(.NTHR(N), .DEPTH(D)) i_thread_issue_picker (
    .clk(clk), .rst_n(rst_n), .thr_active_i(act), .thr_miss_i(miss),
    .thr_wake_i(wake), .redir_valid_i(rv), .redir_tid_i(rtid),
    .redir_hit_i(rhit), .fill_done_i(fd), .iss_valid_o(iss_valid_o),
    .iss_tid_o(iss_tid_o), .req_valid_o(req_valid_o), .req_tid_o(req_tid_o),
    .flush_o(flush_o));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // reference state
  int mc[N]; bit mst[N];
  bit mlv; int mlt, mptr;
  bit mbusy, mstale; int mbt;
  // cache model
  int timer = 0, lat = 4; bit hold = 0;
  bit pv; int pt;
  int issues = 0;
  logic [31:0] rs = 32'h1234_5678;

  task automatic chk(bit ok, string req, int a, int e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  task automatic cyc();
    bit el[N], fl[N], nd[N]; bit ev, rq, fap, alone; int et, rid, cand;
    fd = (timer == 1) && !hold;
    #1;
    ev = 0; et = 0; cand = 0;
    for (int t = 0; t < N; t++) begin
      el[t] = act[t] && !mst[t] && mc[t] != 0 && !(mlv && mlt == t);
      if (act[t] && !mst[t] && mc[t] != 0) cand++;
      fl[t] = miss[t] || (rv && !rhit && rtid == t);
    end
    for (int k = 0; k < N; k++)
      if (!ev && el[(mptr + k) % N]) begin ev = 1; et = (mptr + k) % N; end
    rq = 0; rid = 0;
    for (int t = N - 1; t >= 0; t--) begin
      nd[t] = act[t] && !mst[t] && !fl[t] && (mc[t] - ((ev && et == t) ? 1 : 0)) < D;
      if (nd[t]) begin rq = !mbusy; rid = t; end
    end
    if (ev && nd[et]) rid = et;
    alone = (cand == 1) && mlv && act[mlt] && !mst[mlt] && mc[mlt] != 0;
    // checks
    chk(iss_valid_o == ev, "R4 issue valid", iss_valid_o, ev);
    if (ev) chk(iss_tid_o == et, "R3 round-robin thread", iss_tid_o, et);
    if (alone) chk(iss_valid_o == 0, "R5 bubble for lone thread", iss_valid_o, 0);
    if (pv && iss_valid_o) chk(iss_tid_o != pt, "R2 back-to-back", iss_tid_o, pt);
    chk(req_valid_o == rq, "R7 refill request", req_valid_o, rq);
    if (rq) chk(req_tid_o == rid, "R6 refill thread", req_tid_o, rid);
    for (int t = 0; t < N; t++)
      chk(flush_o[t] == fl[t], miss[t] ? "R9 miss flush" : "R8 redirect flush",
          flush_o[t], fl[t]);
    pv = iss_valid_o; pt = iss_tid_o;
    if (iss_valid_o) issues++;
    fap = mbusy && fd && !mstale && !fl[mbt];
    @(posedge clk);
    for (int t = 0; t < N; t++) begin
      if (ev && et == t) mc[t]--;
      if (fap && mbt == t) mc[t] = D;
      if (fl[t]) mc[t] = 0;
      if (wake[t]) mst[t] = 0;
      if (miss[t]) mst[t] = 1;
    end
    mlv = ev;
    if (ev) begin mlt = et; mptr = (et + 1) % N; end
    if (rq) begin mbusy = 1; mbt = rid; mstale = 0; end
    else begin
      if (mbusy && fl[mbt]) mstale = 1;
      if (mbusy && fd) mbusy = 0;
    end
    if (timer > 1) timer--;
    else if (timer == 1 && fd) timer = 0;
    if (req_valid_o) begin timer = lat; lat = 9 - lat; end
    @(negedge clk);
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; act = 0; miss = 0; wake = 0; rv = 0; rhit = 0; rtid = 0; fd = 0;
    for (int t = 0; t < N; t++) begin mc[t] = 0; mst[t] = 0; end
    mlv = 0; mlt = 0; mptr = 0; mbusy = 0; mstale = 0; mbt = 0; pv = 0; pt = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(iss_valid_o == 0, "R1 no issue in reset", iss_valid_o, 0);
    chk(req_valid_o == 0, "R1 no request in reset", req_valid_o, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) cyc();
    act = 4'b1111;
    #1;
    chk(iss_valid_o == 0, "R1 empty buffers after reset", iss_valid_o, 0);
    act = 4'b0000;
    // R10: one thread, refills held after the first one
    act = 4'b0001;
    while (mc[0] != D) cyc();
    hold = 1; issues = 0;
    repeat (14) cyc();
    chk(issues == D, "R10 issues from one full buffer", issues, D);
    hold = 0;
    repeat (10) cyc();
    // exhaustive active masks
    for (int m = 0; m < 16; m++) begin
      act = 4'(m);
      repeat (40) cyc();
    end
    // random misses, wakes, redirects
    for (int i = 0; i < 6000; i++) begin
      rs = nxt(rs);
      if (i % 32 == 0) act = rs[31:28] | 4'b0001;
      rv = (rs[2:0] == 0); rtid = rs[4:3]; rhit = rs[5];
      miss = (rs[10:6] == 0) ? (4'b0001 << rs[12:11]) : 4'b0000;
      wake = (rs[14:13] == 0) ? rs[19:16] : 4'b0000;
      cyc();
    end
    rv = 0; miss = 0; wake = 4'b1111; cyc(); wake = 0;
    repeat (20) cyc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule